// File: doc/BRIEF.md
# Branch Target Resolution Unit

This unit settles where the instruction index of a 64-bit register machine goes after one of its eight jump opcodes. The sequencer presents the current index, the opcode, a two-bit operand size code, a destination operand that holds either an absolute target or a signed offset, a source operand used as a condition, and the equality flag. One clock later the unit reports whether the jump is taken and which index value to load.

Absolute jumps load the zero-extended target minus one, because the sequencer increments the index after every instruction. Relative jumps sign-extend the offset from the selected width and add it to the current index in two's-complement arithmetic. Each of the two jump kinds comes in four variants: unconditional, taken when the flag is set, taken when the flag is clear, and taken when the full source operand is nonzero. When no jump happens, the current index passes through unchanged so the sequencer can load the output without checking it.

Top module: `branch_resolve`

## Requirements
- R1: While reset is asserted and after it is released, `taken` and `res_valid` are 0 and `next_idx` is 0 until the first request.
- R2: Opcodes 0x038 to 0x03F are jumps. Opcode bit 2 selects relative (1) or absolute (0). Bits 1:0 select the condition: 00 always, 01 flag set, 10 flag clear, 11 source nonzero. Any other opcode is accepted as a request that is not taken.
- R3: An absolute target is the low 8, 16, 32 or 64 bits of `dst_opnd` for size codes 00, 01, 10 and 11, zero-extended to 64 bits.
- R4: A taken absolute jump outputs the target minus one, modulo 2^64. A target of 0 gives all ones.
- R5: A taken relative jump outputs `cur_idx` plus the offset. The offset is the low 8, 16, 32 or 64 bits of `dst_opnd`, selected by the size code and sign-extended. The sum wraps modulo 2^64.
- R6: Flag-conditioned jumps are taken only when `eq_flag` matches the condition (set for 01, clear for 10).
- R7: Source-conditioned jumps test all 64 bits of `src_opnd`, whatever the size code.
- R8: When the condition is false or the opcode is not a jump, `taken` is 0 and `next_idx` equals the `cur_idx` of that request.
- R9: Each request accepted at a clock edge produces its result on the outputs one cycle later. `res_valid` and `taken` stay high for exactly that one cycle, and back-to-back requests give back-to-back results.
- R10: In a cycle with no request, `taken` and `res_valid` return to 0 and `next_idx` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| opcode | input | 10 | Instruction opcode |
| size_code | input | 2 | Operand width select (8/16/32/64 bits) |
| cur_idx | input | 64 | Current instruction index |
| dst_opnd | input | 64 | Target or offset operand |
| src_opnd | input | 64 | Condition operand |
| eq_flag | input | 1 | Equality flag |
| res_valid | output | 1 | Result present, one cycle per request |
| taken | output | 1 | Jump taken for this result |
| next_idx | output | 64 | Index value for the sequencer to load |

## Verification
The bench targets the width boundaries. It drives offsets whose sign bit is set at the selected width, and targets whose upper operand bits are nonzero garbage. A design that sign-extends absolute targets, or zero-extends relative offsets, gives a large wrong index. A target of 0 must wrap to all ones, and a relative sum past the top of the index space must wrap back to a small value; a design that forgets the minus-one, or saturates the sum, is caught there. A source operand that is nonzero only above bit 7 under size code 00 exposes a condition that wrongly looks at the narrow width. Idle cycles and back-to-back requests expose a `taken` that lingers, or results that land in the wrong cycle.

// File: rtl/jr_pkg.sv
package jr_pkg;

   typedef enum logic [1:0] {
      COND_ALWAYS   = 2'b00,
      COND_FLAG_SET = 2'b01,
      COND_FLAG_CLR = 2'b10,
      COND_SRC_NZ   = 2'b11
   } cond_e;

   typedef struct packed {
      logic  is_jump;
      logic  relative;
      cond_e cond;
   } jdec_t;

   localparam int NUM_LANES = 4;
   localparam int LANE_BASE_W = 8;

endpackage

// File: rtl/jr_decode.sv
module jr_decode
   import jr_pkg::*;
#(
   parameter int OPC_W    = 10,
   parameter int JMP_BASE = 'h038
) (
   input  logic [OPC_W-1:0] opcode,
   output jdec_t            dec
);
   localparam int GROUP_W = OPC_W - 3;
   localparam logic [GROUP_W-1:0] GROUP_ID = GROUP_W'(JMP_BASE >> 3);

   generate
      if (OPC_W < 4) begin : g_bad_opc_w
         $error("jr_decode: OPC_W must be at least 4");
      end
      if ((JMP_BASE % 8) != 0) begin : g_bad_base
         $error("jr_decode: JMP_BASE must be a multiple of 8");
      end
   endgenerate

   always_comb begin
      dec.is_jump  = (opcode[OPC_W-1:3] == GROUP_ID);
      dec.relative = opcode[2];
      dec.cond     = cond_e'(opcode[1:0]);
   end
endmodule

// File: rtl/jr_extend.sv
module jr_extend
   import jr_pkg::*;
#(
   parameter int IDX_W = 64
) (
   input  logic [IDX_W-1:0] raw,
   input  logic [1:0]       size_code,
   input  logic             sign_mode,
   output logic [IDX_W-1:0] ext
);
   logic [IDX_W-1:0] lane_ext [NUM_LANES];

   generate
      if (IDX_W < LANE_BASE_W) begin : g_bad_idx_w
         $error("jr_extend: IDX_W must be at least 8");
      end
      for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
         localparam int NAT_W = LANE_BASE_W << k;
         localparam int LW    = (NAT_W > IDX_W) ? IDX_W : NAT_W;
         if (LW < IDX_W) begin : g_narrow
            always_comb begin
               if (sign_mode)
                  lane_ext[k] = {{(IDX_W-LW){raw[LW-1]}}, raw[LW-1:0]};
               else
                  lane_ext[k] = {{(IDX_W-LW){1'b0}}, raw[LW-1:0]};
            end
         end else begin : g_full
            always_comb lane_ext[k] = raw;
         end
      end
   endgenerate

   always_comb ext = lane_ext[size_code];
endmodule

// File: rtl/jr_cond.sv
module jr_cond
   import jr_pkg::*;
#(
   parameter int IDX_W = 64
) (
   input  cond_e            cond,
   input  logic             eq_flag,
   input  logic [IDX_W-1:0] src_opnd,
   output logic             cond_ok
);
   always_comb begin
      unique case (cond)
         COND_ALWAYS:   cond_ok = 1'b1;
         COND_FLAG_SET: cond_ok = eq_flag;
         COND_FLAG_CLR: cond_ok = !eq_flag;
         COND_SRC_NZ:   cond_ok = |src_opnd;
         default:       cond_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import jr_pkg::*;
#(
   parameter int IDX_W    = 64,
   parameter int OPC_W    = 10,
   parameter int JMP_BASE = 'h038
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OPC_W-1:0] opcode,
   input  logic [1:0]       size_code,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic [IDX_W-1:0] dst_opnd,
   input  logic [IDX_W-1:0] src_opnd,
   input  logic             eq_flag,
   output logic             res_valid,
   output logic             taken,
   output logic [IDX_W-1:0] next_idx
);
   localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
   localparam logic [OPC_W-1:0] OPC_ABS_ALWAYS = OPC_W'(JMP_BASE);
   localparam logic [OPC_W-1:0] OPC_ABS_FSET   = OPC_W'(JMP_BASE + 1);
   localparam logic [OPC_W-1:0] OPC_REL_ALWAYS = OPC_W'(JMP_BASE + 4);

   generate
      if (JMP_BASE + 8 > (1 << OPC_W)) begin : g_bad_base
         $error("branch_resolve: JMP_BASE does not fit in OPC_W bits");
      end
   endgenerate

   jdec_t            dec;
   logic [IDX_W-1:0] opnd_ext;
   logic             cond_ok;
   logic             jump_go;
   logic [IDX_W-1:0] target_idx;

   jr_decode #(.OPC_W(OPC_W), .JMP_BASE(JMP_BASE)) u_decode (
      .opcode (opcode),
      .dec    (dec)
   );

   jr_extend #(.IDX_W(IDX_W)) u_extend (
      .raw       (dst_opnd),
      .size_code (size_code),
      .sign_mode (dec.relative),
      .ext       (opnd_ext)
   );

   jr_cond #(.IDX_W(IDX_W)) u_cond (
      .cond     (dec.cond),
      .eq_flag  (eq_flag),
      .src_opnd (src_opnd),
      .cond_ok  (cond_ok)
   );

   always_comb begin
      jump_go = dec.is_jump && cond_ok;
      if (!jump_go)
         target_idx = cur_idx;
      else if (dec.relative)
         target_idx = cur_idx + opnd_ext;
      else
         target_idx = opnd_ext - ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         taken     <= 1'b0;
         next_idx  <= '0;
      end else begin
         res_valid <= req_valid;
         taken     <= req_valid && jump_go;
         if (req_valid)
            next_idx <= target_idx;
      end
   end

   // R9: every request yields a result one cycle later
   p_result_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   // R10: no request means no result, no taken, index held
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!res_valid && !taken && $stable(next_idx)));

   // R4: unconditional absolute 64-bit jump loads target minus one
   p_abs_minus_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && opcode == OPC_ABS_ALWAYS && size_code == 2'b11)
      |=> (taken && next_idx == $past(dst_opnd) - ONE));

   // R5: unconditional relative 64-bit jump adds offset to index
   p_rel_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && opcode == OPC_REL_ALWAYS && size_code == 2'b11)
      |=> (taken && next_idx == $past(cur_idx) + $past(dst_opnd)));

   // R8: failed flag condition passes the current index through
   p_flag_false_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && opcode == OPC_ABS_FSET && !eq_flag)
      |=> (!taken && next_idx == $past(cur_idx)));

   // R9: taken only ever appears with a result
   p_taken_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> res_valid);
endmodule

// File: tb/branch_resolve_tb_top.sv
`timescale 1ns/1ps
module branch_resolve_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [9:0]  opcode = '0;
   logic [1:0]  size_code = '0;
   logic [63:0] cur_idx = '0;
   logic [63:0] dst_opnd = '0;
   logic [63:0] src_opnd = '0;
   logic        eq_flag = 1'b0;
   logic        res_valid;
   logic        taken;
   logic [63:0] next_idx;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   branch_resolve dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opcode(opcode),
      .size_code(size_code), .cur_idx(cur_idx), .dst_opnd(dst_opnd),
      .src_opnd(src_opnd), .eq_flag(eq_flag), .res_valid(res_valid),
      .taken(taken), .next_idx(next_idx)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [9:0] opc, input logic [1:0] sz, input logic [63:0] cur,
                        input logic [63:0] dst, input logic [63:0] src, input logic flg);
      opcode = opc; size_code = sz; cur_idx = cur;
      dst_opnd = dst; src_opnd = src; eq_flag = flg; req_valid = 1'b1;
   endtask

   // one request, result checked at the following negedge
   task automatic one_req(input string tag, input logic [9:0] opc, input logic [1:0] sz,
                          input logic [63:0] cur, input logic [63:0] dst, input logic [63:0] src,
                          input logic flg, input logic exp_tk, input logic [63:0] exp_idx);
      @(negedge clk);
      drive(opc, sz, cur, dst, src, flg);
      @(posedge clk); #1;
      req_valid = 1'b0;
      @(negedge clk);
      chk({tag, " valid"}, 64'(res_valid), 64'd1);
      chk({tag, " taken"}, 64'(taken), 64'(exp_tk));
      chk({tag, " idx"}, next_idx, exp_idx);
   endtask

   task automatic t_reset;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset valid", 64'(res_valid), 64'd0);
      chk("R1 reset taken", 64'(taken), 64'd0);
      chk("R1 reset idx", next_idx, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release idx", next_idx, 64'd0);
   endtask

   task automatic t_absolute;
      one_req("R3 abs size00", 10'h038, 2'b00, 64'd77, 64'hFFFF_FFFF_FFFF_FF05, 0, 0, 1, 64'd4);
      one_req("R3 abs size01", 10'h038, 2'b01, 64'd77, 64'hFFFF_FFFF_1234_ABCD, 0, 0, 1, 64'h0000_0000_0000_ABCC);
      one_req("R3 abs size10", 10'h038, 2'b10, 64'd77, 64'h1111_2222_8000_0000, 0, 0, 1, 64'h0000_0000_7FFF_FFFF);
      one_req("R4 abs size11", 10'h038, 2'b11, 64'd77, 64'h0000_0000_0000_1000, 0, 0, 1, 64'h0000_0000_0000_0FFF);
      one_req("R4 abs target zero", 10'h038, 2'b00, 64'd9, 64'h0000_0000_0000_0100, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_relative;
      one_req("R5 rel neg byte", 10'h03C, 2'b00, 64'd1000, 64'h0000_0000_0000_0080, 0, 0, 1, 64'd872);
      one_req("R5 rel pos byte", 10'h03C, 2'b00, 64'd10, 64'hFFFF_FFFF_FFFF_FF7F, 0, 0, 1, 64'd137);
      one_req("R5 rel neg short", 10'h03C, 2'b01, 64'd5, 64'h0000_0000_0000_FFFE, 0, 0, 1, 64'd3);
      one_req("R5 rel neg int", 10'h03C, 2'b10, 64'h10, 64'h0000_0000_FFFF_FFF0, 0, 0, 1, 64'd0);
      one_req("R5 rel wrap down", 10'h03C, 2'b11, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
      one_req("R5 rel wrap up", 10'h03C, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, 0, 1, 64'd1);
   endtask

   task automatic t_flag;
      one_req("R6 abs flag set hit", 10'h039, 2'b00, 64'd50, 64'd20, 0, 1, 1, 64'd19);
      one_req("R8 abs flag set miss", 10'h039, 2'b00, 64'd50, 64'd20, 0, 0, 0, 64'd50);
      one_req("R6 abs flag clr hit", 10'h03A, 2'b00, 64'd50, 64'd30, 0, 0, 1, 64'd29);
      one_req("R8 abs flag clr miss", 10'h03A, 2'b00, 64'd51, 64'd30, 0, 1, 0, 64'd51);
      one_req("R6 rel flag set hit", 10'h03D, 2'b00, 64'd50, 64'h0000_0000_0000_00FF, 0, 1, 1, 64'd49);
      one_req("R6 rel flag clr hit", 10'h03E, 2'b00, 64'd50, 64'd4, 0, 0, 1, 64'd54);
      one_req("R8 rel flag clr miss", 10'h03E, 2'b00, 64'd52, 64'd4, 0, 1, 0, 64'd52);
   endtask

   task automatic t_source;
      one_req("R7 abs src high bit", 10'h03B, 2'b00, 64'd8, 64'd100, 64'h8000_0000_0000_0000, 0, 1, 64'd99);
      one_req("R8 abs src zero", 10'h03B, 2'b00, 64'd8, 64'd100, 64'd0, 1, 0, 64'd8);
      one_req("R7 rel src hit", 10'h03F, 2'b01, 64'd8, 64'h0000_0000_0000_0010, 64'h0000_0100_0000_0000, 0, 1, 64'd24);
      one_req("R8 rel src zero", 10'h03F, 2'b01, 64'd9, 64'd16, 64'd0, 1, 0, 64'd9);
   endtask

   task automatic t_non_jump;
      one_req("R2 opcode 0x037", 10'h037, 2'b11, 64'd333, 64'd5, 64'd1, 1, 0, 64'd333);
      one_req("R2 opcode 0x040", 10'h040, 2'b11, 64'd334, 64'd5, 64'd1, 1, 0, 64'd334);
      one_req("R2 opcode 0x238", 10'h238, 2'b11, 64'd335, 64'd5, 64'd1, 1, 0, 64'd335);
   endtask

   task automatic t_idle_hold;
      one_req("R10 setup", 10'h038, 2'b00, 64'd1, 64'd42, 0, 0, 1, 64'd41);
      @(negedge clk);
      dst_opnd = 64'd7; cur_idx = 64'd3;
      @(negedge clk);
      chk("R10 idle valid", 64'(res_valid), 64'd0);
      chk("R10 idle taken", 64'(taken), 64'd0);
      chk("R10 idle idx held", next_idx, 64'd41);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      drive(10'h038, 2'b00, 64'd0, 64'd11, 0, 0);
      @(negedge clk);
      chk("R9 b2b first taken", 64'(taken), 64'd1);
      chk("R9 b2b first idx", next_idx, 64'd10);
      drive(10'h039, 2'b00, 64'd60, 64'd11, 0, 0);
      @(negedge clk);
      chk("R9 b2b second valid", 64'(res_valid), 64'd1);
      chk("R9 b2b second taken", 64'(taken), 64'd0);
      chk("R9 b2b second idx", next_idx, 64'd60);
      drive(10'h03C, 2'b00, 64'd60, 64'd1, 0, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 b2b third taken", 64'(taken), 64'd1);
      chk("R9 b2b third idx", next_idx, 64'd61);
      @(negedge clk);
      chk("R9 pulse ends valid", 64'(res_valid), 64'd0);
      chk("R9 pulse ends taken", 64'(taken), 64'd0);
   endtask

   task automatic finish_up;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      t_reset();
      t_absolute();
      t_relative();
      t_flag();
      t_source();
      t_non_jump();
      t_idle_hold();
      t_back_to_back();
      done = 1'b1;
      finish_up();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         finish_up();
      end
   end
endmodule